// File: doc/BRIEF.md
# Gate Driver Protection Sequencer

This block is the clocked decision logic that sits between a logic-level drive request and the gate stage of a power MOSFET driver. It takes one drive command and two comparator flags: a floating-supply undervoltage flag and a drain-source overvoltage flag. From these it produces a non-inverting gate enable and a fault status. All three inputs are asynchronous, so each one passes through a two-stage synchronizer before the control state machine uses it.

After every rising command edge the overvoltage flag is masked for a blanking window. The window gives the switch time to reach full enhancement. Once the window has ended, an overvoltage trip forces the gate off and latches it off. Only a new rising command edge releases the latch. The supply flag matters only while the switch is off. A turn-on request made while the supply is low is refused, and the block then waits for a fresh rising edge that arrives with the supply good. A low supply that appears while the gate is already on is ignored. The blanking length is derived from the clock frequency and a time in nanoseconds, both given as parameters.

Top module: `gate_prot_seq`

## Requirements
- R1: The gate enable is non-inverting. A rising edge on `cmd_i` with the supply good sets `gate_o` high on the third clock edge after the input change (two synchronizer stages plus one state register). A falling `cmd_i` clears `gate_o` on the third edge after the change.
- R2: During the first BLANK_CYCLES clock cycles of each turn-on, `ov_i` has no effect, and `gate_o` stays high through any overvoltage pulse that ends inside that window. BLANK_CYCLES = round(CLK_HZ × BLANK_NS / 10^9), with a minimum of 1.
- R3: When the synchronized `ov_i` is high after the window has ended, `gate_o` goes low and `fault_o` goes high, both on the third clock edge after `ov_i` rises.
- R4: After an overvoltage trip, the gate stays off and `fault_o` stays high as long as `cmd_i` does not produce a new rising edge, whether `cmd_i` stays high or goes low. A new rising edge with the supply good turns the gate on and clears `fault_o`.
- R5: If the synchronized `uv_i` is high when a rising command edge is taken, the request is refused: `gate_o` stays low and `fault_o` goes high.
- R6: `uv_i` going high while the gate is on has no effect, and `gate_o` stays high until `cmd_i` falls.
- R7: A refused request is not retried when `uv_i` clears with `cmd_i` still high. The gate stays low until `cmd_i` falls and rises again. The fall of `cmd_i` clears `fault_o`.
- R8: A falling `cmd_i` during the blanking window cancels the window. The next rising edge starts a full window of BLANK_CYCLES again.
- R9: A synchronous active-high `rst` drives `gate_o` and `fault_o` low on the next clock edge. It also clears the fault latch, the blanking counter and the synchronizers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 1 | Asynchronous drive command, high requests the gate on |
| uv_i | input | 1 | Asynchronous floating-supply undervoltage flag |
| ov_i | input | 1 | Asynchronous drain-source overvoltage flag |
| gate_o | output | 1 | Gate enable, high drives the switch on |
| fault_o | output | 1 | High while tripped on overvoltage or refusing for undervoltage |

## Verification
The bench builds the block with CLK_HZ = 200 MHz and BLANK_NS = 100, which gives a 20-cycle blanking window. At that size, random command pulses of 1 to 40 cycles regularly end before the window does, end just after it, or outlast it. Random stimulus therefore reaches window cancellation, overvoltage pulses at the window boundary, and trips followed by re-arming. Directed sequences then place overvoltage pulses inside a restarted window and undervoltage changes on each side of a turn-on.

// File: rtl/gdps_pkg.sv
package gdps_pkg;

    typedef enum logic [2:0] {
        GS_IDLE,
        GS_BLANK,
        GS_DRIVE,
        GS_TRIP,
        GS_HOLDOFF
    } gd_state_e;

    typedef struct packed {
        logic cmd;
        logic uv;
        logic ov;
    } gd_flags_t;

    localparam int FLAG_W = $bits(gd_flags_t);

    function automatic int calc_blank(input longint clk_hz, input longint blank_ns);
        longint cyc;
        cyc = (clk_hz * blank_ns + 64'sd500_000_000) / 64'sd1_000_000_000;
        if (cyc < 1) cyc = 1;
        return int'(cyc);
    endfunction

    function automatic logic state_drives(input gd_state_e s);
        return (s == GS_BLANK) || (s == GS_DRIVE);
    endfunction

    function automatic logic state_faulted(input gd_state_e s);
        return (s == GS_TRIP) || (s == GS_HOLDOFF);
    endfunction

endpackage

// File: rtl/gdps_sync.sv
module gdps_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
        end else begin
            pipe[0] <= async_i;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign sync_o = pipe[STAGES-1];
endmodule

// File: rtl/gdps_blank_timer.sv
module gdps_blank_timer #(
    parameter int CYCLES = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] TOP = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                       cnt <= '0;
        else if (load_i)               cnt <= TOP;
        else if (!run_i)               cnt <= '0;
        else if (cnt != '0)            cnt <= cnt - 1'b1;
    end

    assign expired_o = (cnt == '0);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= TOP);  // R2
    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !load_i) |=> expired_o);  // R8
endmodule

// File: rtl/gdps_ctrl.sv
module gdps_ctrl
    import gdps_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  gd_flags_t flags_i,
    input  logic      expired_i,
    output logic      load_o,
    output logic      run_o,
    output gd_state_e state_o
);
    gd_state_e state, state_nx;
    logic      cmd_d;
    logic      cmd_rise;

    always_ff @(posedge clk) begin
        if (rst) cmd_d <= 1'b0;
        else     cmd_d <= flags_i.cmd;
    end

    assign cmd_rise = flags_i.cmd && !cmd_d;

    always_comb begin
        state_nx = state;
        unique case (state)
            GS_IDLE: begin
                if (cmd_rise) state_nx = flags_i.uv ? GS_HOLDOFF : GS_BLANK;
            end
            GS_BLANK: begin
                if (!flags_i.cmd)  state_nx = GS_IDLE;
                else if (expired_i) state_nx = GS_DRIVE;
            end
            GS_DRIVE: begin
                if (!flags_i.cmd)  state_nx = GS_IDLE;
                else if (flags_i.ov) state_nx = GS_TRIP;
            end
            GS_TRIP: begin
                if (cmd_rise) state_nx = flags_i.uv ? GS_HOLDOFF : GS_BLANK;
            end
            GS_HOLDOFF: begin
                if (!flags_i.cmd) state_nx = GS_IDLE;
            end
            default: state_nx = GS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= GS_IDLE;
        else     state <= state_nx;
    end

    assign load_o  = (state_nx == GS_BLANK) && (state != GS_BLANK);
    assign run_o   = (state == GS_BLANK);
    assign state_o = state;

    AST_CMD_LOW_OFF: assert property (@(posedge clk) disable iff (rst)
        !flags_i.cmd |=> !state_drives(state));  // R1
    AST_BLANK_MASKS_OV: assert property (@(posedge clk) disable iff (rst)
        (state == GS_BLANK && flags_i.cmd) |=> state_drives(state));  // R2
    AST_OV_TRIPS: assert property (@(posedge clk) disable iff (rst)
        (state == GS_DRIVE && flags_i.cmd && flags_i.ov) |=> (state == GS_TRIP));  // R3
    AST_TRIP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == GS_TRIP && !cmd_rise) |=> (state == GS_TRIP));  // R4
    AST_UV_REFUSES: assert property (@(posedge clk) disable iff (rst)
        (cmd_rise && flags_i.uv) |=> !state_drives(state));  // R5
    AST_UV_IGNORED_ON: assert property (@(posedge clk) disable iff (rst)
        (state == GS_DRIVE && flags_i.cmd && !flags_i.ov) |=> (state == GS_DRIVE));  // R6
    AST_HOLDOFF_WAITS: assert property (@(posedge clk) disable iff (rst)
        (state == GS_HOLDOFF && flags_i.cmd) |=> (state == GS_HOLDOFF));  // R7
    AST_WINDOW_RESTART: assert property (@(posedge clk) disable iff (rst)
        load_o |=> !expired_i || (state != GS_BLANK) || $past(expired_i));  // R8
endmodule

// File: rtl/gate_prot_seq.sv
module gate_prot_seq
    import gdps_pkg::*;
#(
    parameter longint CLK_HZ      = 200_000_000,
    parameter longint BLANK_NS    = 2000,
    parameter int     SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_i,
    input  logic uv_i,
    input  logic ov_i,
    output logic gate_o,
    output logic fault_o
);
    localparam int BLANK_CYCLES = calc_blank(CLK_HZ, BLANK_NS);

    gd_flags_t raw_flags, sync_flags;
    logic      tmr_load, tmr_run, tmr_expired;
    gd_state_e state;

    always_comb begin
        raw_flags.cmd = cmd_i;
        raw_flags.uv  = uv_i;
        raw_flags.ov  = ov_i;
    end

    gdps_sync #(.STAGES(SYNC_STAGES), .W(FLAG_W)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (raw_flags),
        .sync_o  (sync_flags)
    );

    gdps_blank_timer #(.CYCLES(BLANK_CYCLES)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .load_i    (tmr_load),
        .run_i     (tmr_run),
        .expired_o (tmr_expired)
    );

    gdps_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .flags_i   (sync_flags),
        .expired_i (tmr_expired),
        .load_o    (tmr_load),
        .run_o     (tmr_run),
        .state_o   (state)
    );

    assign gate_o  = state_drives(state);
    assign fault_o = state_faulted(state);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!gate_o && !fault_o));  // R9
    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(gate_o && fault_o));  // R3
endmodule

// File: tb/test_gate_prot_seq.sv
module test_gate_prot_seq;
    localparam int BL = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd = 1'b0, uv = 1'b0, ov = 1'b0;
    logic gate, fault;

    int n_chk = 0, n_fail = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;
    string cur_req = "R9";

    always #2.5 clk = ~clk;

    gate_prot_seq #(.CLK_HZ(200_000_000), .BLANK_NS(100), .SYNC_STAGES(2)) i_gate_prot_seq (
        .clk(clk), .rst(rst), .cmd_i(cmd), .uv_i(uv), .ov_i(ov),
        .gate_o(gate), .fault_o(fault)
    );

    // Reference model built from the requirements: 0 off, 1 blank, 2 on, 3 tripped, 4 refused
    logic c1, c2, c3, u1, u2, o1, o2;
    int   m_st, m_cnt;

    function automatic logic exp_gate(input int st);
        return (st == 1) || (st == 2);
    endfunction
    function automatic logic exp_fault(input int st);
        return (st == 3) || (st == 4);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            c1 <= 0; c2 <= 0; c3 <= 0; u1 <= 0; u2 <= 0; o1 <= 0; o2 <= 0;
            m_st <= 0; m_cnt <= 0;
        end else begin
            c1 <= cmd; c2 <= c1; c3 <= c2;
            u1 <= uv;  u2 <= u1;
            o1 <= ov;  o2 <= o1;
            case (m_st)
                0, 3: if (c2 && !c3) begin
                    if (u2) m_st <= 4;
                    else begin m_st <= 1; m_cnt <= BL - 1; end
                end
                1: if (!c2) m_st <= 0;
                   else if (m_cnt == 0) m_st <= 2;
                   else m_cnt <= m_cnt - 1;
                2: if (!c2) m_st <= 0;
                   else if (o2) m_st <= 3;
                4: if (!c2) m_st <= 0;
                default: m_st <= 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (model_on && !done) begin
            n_chk++;
            if (gate !== exp_gate(m_st) || fault !== exp_fault(m_st)) begin
                n_fail++;
                $display("FAIL %s model gate=%b fault=%b expected gate=%b fault=%b t=%0t",
                         cur_req, gate, fault, exp_gate(m_st), exp_fault(m_st), $time);
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic g_exp, input logic f_exp);
        n_chk++;
        if (gate !== g_exp || fault !== f_exp) begin
            n_fail++;
            $display("FAIL %s gate=%b fault=%b expected gate=%b fault=%b t=%0t",
                     req, gate, fault, g_exp, f_exp, $time);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        wait_n(3);
        check("R9", 1'b0, 1'b0);
        rst = 1'b0;
        model_on = 1'b1;

        // R1: turn-on latency and non-inverting drive
        cur_req = "R1";
        cmd = 1; wait_n(2); check("R1", 1'b0, 1'b0);
        wait_n(1); check("R1", 1'b1, 1'b0);
        wait_n(40);
        cmd = 0; wait_n(3); check("R1", 1'b0, 1'b0);
        wait_n(5);

        // R2: overvoltage pulse inside blanking window is ignored
        cur_req = "R2";
        cmd = 1; wait_n(4);
        ov = 1; wait_n(8); ov = 0;
        wait_n(30); check("R2", 1'b1, 1'b0);

        // R3: overvoltage after the window trips
        cur_req = "R3";
        ov = 1; wait_n(2); check("R3", 1'b1, 1'b0);
        wait_n(1); check("R3", 1'b0, 1'b1);
        ov = 0;

        // R4: latch holds with command high, then low, until fresh rise
        cur_req = "R4";
        wait_n(30); check("R4", 1'b0, 1'b1);
        cmd = 0; wait_n(10); check("R4", 1'b0, 1'b1);
        cmd = 1; wait_n(4); check("R4", 1'b1, 1'b0);
        wait_n(30);

        // R6: undervoltage while on is ignored
        cur_req = "R6";
        uv = 1; wait_n(20); check("R6", 1'b1, 1'b0);
        cmd = 0; wait_n(5); check("R6", 1'b0, 1'b0);

        // R5: refusal under undervoltage
        cur_req = "R5";
        cmd = 1; wait_n(5); check("R5", 1'b0, 1'b1);

        // R7: supply recovery with command held does not turn on
        cur_req = "R7";
        uv = 0; wait_n(30); check("R7", 1'b0, 1'b1);
        cmd = 0; wait_n(4); check("R7", 1'b0, 1'b0);
        cmd = 1; wait_n(4); check("R7", 1'b1, 1'b0);
        cmd = 0; wait_n(6);

        // R8: fall during window cancels it, next rise restarts a full window
        cur_req = "R8";
        cmd = 1; wait_n(10);
        cmd = 0; wait_n(4);
        cmd = 1; wait_n(15);
        ov = 1; wait_n(5); ov = 0;
        wait_n(15); check("R8", 1'b1, 1'b0);
        cmd = 0; wait_n(6);

        // Random segments checked against the model every cycle
        cur_req = "R3";
        for (int seg = 0; seg < 1500; seg++) begin
            cmd = ($urandom_range(0, 99) < 60);
            uv  = ($urandom_range(0, 99) < 20);
            ov  = ($urandom_range(0, 99) < 25);
            wait_n($urandom_range(1, 40));
        end

        // R9: reset mid-operation
        cur_req = "R9";
        cmd = 1; uv = 0; ov = 0; wait_n(10);
        model_on = 1'b0;
        rst = 1; wait_n(1); check("R9", 1'b0, 1'b0);
        rst = 0; cmd = 0; wait_n(2);
        model_on = 1'b1;
        wait_n(5);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule